// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the hardwired control unit of a small multicycle processor in which one memory serves both instructions and data and a single ALU does every calculation: incrementing the PC, computing branch targets, computing effective addresses and executing instructions. Each cycle it turns its current step, the opcode held in the instruction register and the ALU zero flag into the full set of datapath strobes and multiplexer selects.

Every instruction starts with a fetch step and then a decode step. The fetch step loads the instruction register and writes PC+4 back to the PC. The decode step computes the branch target ahead of time in case the instruction is a branch. After decode the sequencer dispatches on the opcode to a short per-class sequence and then returns to fetch. The instruction memory and the data memory each raise a wait flag of any length. While the matching wait flag is high, the sequencer holds its current step and keeps every state-changing strobe low. The registers, register file and memory sit outside this block.

Top module: `mc_ctrl`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it is released, the block is in the fetch step. mem_rd_o=1 and addr_sel_o=0 (0 selects the PC as memory address). reg_wr_o, mem_wr_o and pc_wr_cond_o are 0.
- R2: In the fetch step with imem_wait_i low, ir_wr_o=1 and pc_wr_o=1. The selects are pc_src_o=0 (0 = the ALU result), alu_a_sel_o=0 (0 = PC), alu_b_sel_o=2'b00 (00 = constant 4) and alu_op_o=2'b00 (00 = add). The next cycle is the decode step.
- R3: The decode step asserts no write enable. It sets alu_a_sel_o=0, alu_b_sel_o=2'b10 (10 = extended immediate shifted left by 2), ext_sign_o=1 (1 = sign extend, 0 = zero extend) and alu_op_o=2'b00. It then dispatches on opcode_i: 6'h00 register-register, 6'h0D OR-immediate, 6'h23 load word, 6'h2B store word, 6'h04 branch-if-equal.
- R4: Register-register takes one execute cycle and then one write-back cycle. Execute uses alu_a_sel_o=1 (1 = register A), alu_b_sel_o=2'b01 (01 = register B) and alu_op_o=2'b10 (10 = function field). Write-back uses reg_wr_o=1, reg_dst_o=1 (1 = rd, 0 = rt) and wb_sel_o=0 (0 = ALUout, 1 = memory data). The sequencer then returns to fetch.
- R5: OR-immediate takes one execute cycle and then one write-back cycle. Execute uses alu_a_sel_o=1, alu_b_sel_o=2'b11 (11 = extended immediate), ext_sign_o=0 and alu_op_o=2'b11 (11 = OR). Write-back uses reg_wr_o=1, reg_dst_o=0 and wb_sel_o=0.
- R6: Load word takes three cycles. The address cycle uses alu_a_sel_o=1, alu_b_sel_o=2'b11, ext_sign_o=1 and alu_op_o=2'b00. The read cycle uses mem_rd_o=1 and addr_sel_o=1. The write-back cycle uses reg_wr_o=1, reg_dst_o=0 and wb_sel_o=1.
- R7: Store word takes an address cycle like load word's and then a write cycle with mem_wr_o=1 and addr_sel_o=1. The sequencer then returns to fetch.
- R8: Branch-if-equal takes one cycle with alu_a_sel_o=1, alu_b_sel_o=2'b01, alu_op_o=2'b01 (01 = subtract), pc_wr_cond_o=1 and pc_src_o=1 (1 = ALUout). The sequencer then returns to fetch.
- R9: While imem_wait_i is high in the fetch step, the block stays in fetch with mem_rd_o=1, and ir_wr_o and pc_wr_o are 0.
- R10: While dmem_wait_i is high in the load read cycle or the store write cycle, the block stays in that cycle, and mem_wr_o and reg_wr_o are 0.
- R11: An opcode outside the five listed ones sends decode straight back to fetch, and no write enable is asserted.
- R12: pc_en_o equals pc_wr_o OR (pc_wr_cond_o AND zero_i) in every cycle, so a branch loads its target only when zero_i is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| opcode_i | input | 6 | Opcode field from the instruction register |
| zero_i | input | 1 | ALU zero flag |
| imem_wait_i | input | 1 | Instruction fetch not yet complete |
| dmem_wait_i | input | 1 | Data access not yet complete |
| ir_wr_o | output | 1 | Load the instruction register |
| pc_wr_o | output | 1 | Unconditional PC write |
| pc_wr_cond_o | output | 1 | PC write qualified by zero |
| pc_en_o | output | 1 | Resolved PC load enable |
| pc_src_o | output | 1 | PC source: 0 ALU result, 1 ALUout |
| addr_sel_o | output | 1 | Memory address: 0 PC, 1 ALUout |
| mem_rd_o | output | 1 | Memory read |
| mem_wr_o | output | 1 | Memory write |
| reg_wr_o | output | 1 | Register file write |
| reg_dst_o | output | 1 | Destination: 0 rt, 1 rd |
| wb_sel_o | output | 1 | Write data: 0 ALUout, 1 memory data |
| alu_a_sel_o | output | 1 | ALU A: 0 PC, 1 register A |
| alu_b_sel_o | output | 2 | ALU B: 00 four, 01 B, 10 imm<<2, 11 imm |
| alu_op_o | output | 2 | 00 add, 01 sub, 10 function, 11 OR |
| ext_sign_o | output | 1 | Immediate extension: 1 sign, 0 zero |

## Verification
The assertions check in every cycle that a stalled fetch or data access holds its step with all write strobes low. They also check that at most one of the instruction, register and memory writes is active at a time, that a register or memory write is always followed by fetch, and that the fetch and branch select codes are consistent. Only the bench scenarios can show the full per-opcode sequences with their exact select values, their cycle counts, the fall-back on unknown opcodes and the load/store split after the shared address cycle. The bench checks these against a behavioural step model under both directed and random wait patterns.

// File: rtl/mc_ctrl_pkg.sv
package mc_ctrl_pkg;
  parameter int OP_W = 6;

  localparam logic [OP_W-1:0] OPC_RTYPE = 6'h00;
  localparam logic [OP_W-1:0] OPC_ORI   = 6'h0D;
  localparam logic [OP_W-1:0] OPC_LD    = 6'h23;
  localparam logic [OP_W-1:0] OPC_ST    = 6'h2B;
  localparam logic [OP_W-1:0] OPC_BEQ   = 6'h04;

  localparam int SEL_W = 2;
  localparam logic [SEL_W-1:0] ALU_ADD  = 2'b00;
  localparam logic [SEL_W-1:0] ALU_SUB  = 2'b01;
  localparam logic [SEL_W-1:0] ALU_FUNC = 2'b10;
  localparam logic [SEL_W-1:0] ALU_OR   = 2'b11;

  localparam logic [SEL_W-1:0] SRCB_FOUR = 2'b00;
  localparam logic [SEL_W-1:0] SRCB_REG  = 2'b01;
  localparam logic [SEL_W-1:0] SRCB_BOFS = 2'b10;
  localparam logic [SEL_W-1:0] SRCB_IMM  = 2'b11;

  typedef enum logic [3:0] {
    ST_FETCH, ST_DECODE, ST_EX_R, ST_WB_R, ST_EX_ORI, ST_WB_ORI,
    ST_EX_ADDR, ST_MEM_RD, ST_WB_LD, ST_MEM_WR, ST_EX_BR
  } mc_state_e;

  typedef enum logic [2:0] {
    CL_R, CL_ORI, CL_LD, CL_ST, CL_BR, CL_BAD
  } op_class_e;

  typedef struct packed {
    logic             ir_wr;
    logic             pc_wr;
    logic             pc_wr_cond;
    logic             pc_src;
    logic             addr_sel;
    logic             mem_rd;
    logic             mem_wr;
    logic             reg_wr;
    logic             reg_dst;
    logic             wb_sel;
    logic             alu_a_sel;
    logic [SEL_W-1:0] alu_b_sel;
    logic [SEL_W-1:0] alu_op;
    logic             ext_sign;
  } mc_ctrl_t;
endpackage

// File: rtl/mc_op_class.sv
module mc_op_class
  import mc_ctrl_pkg::*;
(
  input  logic [OP_W-1:0] opcode_i,
  output op_class_e       cls_o
);
  always_comb begin
    unique case (opcode_i)
      OPC_RTYPE: cls_o = CL_R;
      OPC_ORI:   cls_o = CL_ORI;
      OPC_LD:    cls_o = CL_LD;
      OPC_ST:    cls_o = CL_ST;
      OPC_BEQ:   cls_o = CL_BR;
      default:   cls_o = CL_BAD;
    endcase
  end
endmodule

// File: rtl/mc_next_state.sv
module mc_next_state
  import mc_ctrl_pkg::*;
(
  input  mc_state_e state_i,
  input  op_class_e cls_i,
  input  logic      imem_wait_i,
  input  logic      dmem_wait_i,
  output mc_state_e state_o
);
  always_comb begin
    state_o = ST_FETCH;
    unique case (state_i)
      ST_FETCH:  state_o = imem_wait_i ? ST_FETCH : ST_DECODE;
      ST_DECODE: begin
        unique case (cls_i)
          CL_R:          state_o = ST_EX_R;
          CL_ORI:        state_o = ST_EX_ORI;
          CL_LD, CL_ST:  state_o = ST_EX_ADDR;
          CL_BR:         state_o = ST_EX_BR;
          default:       state_o = ST_FETCH;
        endcase
      end
      ST_EX_R:    state_o = ST_WB_R;
      ST_EX_ORI:  state_o = ST_WB_ORI;
      // opcode comes from IR, so it is still valid here
      ST_EX_ADDR: state_o = (cls_i == CL_LD) ? ST_MEM_RD :
                            (cls_i == CL_ST) ? ST_MEM_WR : ST_FETCH;
      ST_MEM_RD:  state_o = dmem_wait_i ? ST_MEM_RD : ST_WB_LD;
      ST_MEM_WR:  state_o = dmem_wait_i ? ST_MEM_WR : ST_FETCH;
      default:    state_o = ST_FETCH;
    endcase
  end
endmodule

// File: rtl/mc_ctrl_decode.sv
module mc_ctrl_decode
  import mc_ctrl_pkg::*;
(
  input  mc_state_e state_i,
  input  logic      imem_wait_i,
  input  logic      dmem_wait_i,
  output mc_ctrl_t  ctrl_o
);
  always_comb begin
    ctrl_o          = '0;
    ctrl_o.ext_sign = 1'b1;
    unique case (state_i)
      ST_FETCH: begin
        ctrl_o.mem_rd    = 1'b1;
        ctrl_o.ir_wr     = !imem_wait_i;
        ctrl_o.pc_wr     = !imem_wait_i;
        ctrl_o.alu_b_sel = SRCB_FOUR;
        ctrl_o.alu_op    = ALU_ADD;
      end
      ST_DECODE: begin
        ctrl_o.alu_b_sel = SRCB_BOFS;
        ctrl_o.alu_op    = ALU_ADD;
      end
      ST_EX_R: begin
        ctrl_o.alu_a_sel = 1'b1;
        ctrl_o.alu_b_sel = SRCB_REG;
        ctrl_o.alu_op    = ALU_FUNC;
      end
      ST_WB_R: begin
        ctrl_o.reg_wr  = 1'b1;
        ctrl_o.reg_dst = 1'b1;
      end
      ST_EX_ORI: begin
        ctrl_o.alu_a_sel = 1'b1;
        ctrl_o.alu_b_sel = SRCB_IMM;
        ctrl_o.alu_op    = ALU_OR;
        ctrl_o.ext_sign  = 1'b0;
      end
      ST_WB_ORI: ctrl_o.reg_wr = 1'b1;
      ST_EX_ADDR: begin
        ctrl_o.alu_a_sel = 1'b1;
        ctrl_o.alu_b_sel = SRCB_IMM;
        ctrl_o.alu_op    = ALU_ADD;
      end
      ST_MEM_RD: begin
        ctrl_o.addr_sel = 1'b1;
        ctrl_o.mem_rd   = 1'b1;
      end
      ST_WB_LD: begin
        ctrl_o.reg_wr = 1'b1;
        ctrl_o.wb_sel = 1'b1;
      end
      ST_MEM_WR: begin
        ctrl_o.addr_sel = 1'b1;
        ctrl_o.mem_wr   = !dmem_wait_i;
      end
      ST_EX_BR: begin
        ctrl_o.alu_a_sel  = 1'b1;
        ctrl_o.alu_b_sel  = SRCB_REG;
        ctrl_o.alu_op     = ALU_SUB;
        ctrl_o.pc_wr_cond = 1'b1;
        ctrl_o.pc_src     = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/mc_ctrl.sv
module mc_ctrl
  import mc_ctrl_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [OP_W-1:0]  opcode_i,
  input  logic             zero_i,
  input  logic             imem_wait_i,
  input  logic             dmem_wait_i,
  output logic             ir_wr_o,
  output logic             pc_wr_o,
  output logic             pc_wr_cond_o,
  output logic             pc_en_o,
  output logic             pc_src_o,
  output logic             addr_sel_o,
  output logic             mem_rd_o,
  output logic             mem_wr_o,
  output logic             reg_wr_o,
  output logic             reg_dst_o,
  output logic             wb_sel_o,
  output logic             alu_a_sel_o,
  output logic [SEL_W-1:0] alu_b_sel_o,
  output logic [SEL_W-1:0] alu_op_o,
  output logic             ext_sign_o
);
  mc_state_e state_q, state_d;
  op_class_e cls;
  mc_ctrl_t  ctrl;

  mc_op_class i_cls (.opcode_i(opcode_i), .cls_o(cls));

  mc_next_state i_nxt (
    .state_i(state_q), .cls_i(cls),
    .imem_wait_i(imem_wait_i), .dmem_wait_i(dmem_wait_i),
    .state_o(state_d)
  );

  mc_ctrl_decode i_dec (
    .state_i(state_q), .imem_wait_i(imem_wait_i),
    .dmem_wait_i(dmem_wait_i), .ctrl_o(ctrl)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_FETCH;
    else         state_q <= state_d;
  end

  assign ir_wr_o      = ctrl.ir_wr;
  assign pc_wr_o      = ctrl.pc_wr;
  assign pc_wr_cond_o = ctrl.pc_wr_cond;
  assign pc_en_o      = ctrl.pc_wr | (ctrl.pc_wr_cond & zero_i);
  assign pc_src_o     = ctrl.pc_src;
  assign addr_sel_o   = ctrl.addr_sel;
  assign mem_rd_o     = ctrl.mem_rd;
  assign mem_wr_o     = ctrl.mem_wr;
  assign reg_wr_o     = ctrl.reg_wr;
  assign reg_dst_o    = ctrl.reg_dst;
  assign wb_sel_o     = ctrl.wb_sel;
  assign alu_a_sel_o  = ctrl.alu_a_sel;
  assign alu_b_sel_o  = ctrl.alu_b_sel;
  assign alu_op_o     = ctrl.alu_op;
  assign ext_sign_o   = ctrl.ext_sign;
endmodule

// File: rtl/mc_ctrl_chk.sv
module mc_ctrl_chk
  import mc_ctrl_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             imem_wait_i,
  input logic             dmem_wait_i,
  input logic             ir_wr_o,
  input logic             pc_wr_o,
  input logic             pc_wr_cond_o,
  input logic             pc_src_o,
  input logic             addr_sel_o,
  input logic             mem_rd_o,
  input logic             mem_wr_o,
  input logic             reg_wr_o,
  input logic [SEL_W-1:0] alu_b_sel_o,
  input logic [SEL_W-1:0] alu_op_o,
  input mc_state_e        state_q
);
  p_fetch_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FETCH && imem_wait_i) |=> (mem_rd_o && !addr_sel_o && state_q == ST_FETCH));

  p_fetch_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FETCH && imem_wait_i) |-> !(ir_wr_o || pc_wr_o || reg_wr_o || mem_wr_o));

  p_rd_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_o && addr_sel_o && dmem_wait_i) |=> (mem_rd_o && addr_sel_o));

  p_wr_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_MEM_WR && dmem_wait_i) |=> (state_q == ST_MEM_WR));

  p_wr_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_MEM_WR && dmem_wait_i) |-> !(mem_wr_o || reg_wr_o));

  p_one_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ir_wr_o, reg_wr_o, mem_wr_o}));

  p_decode_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ir_wr_o |=> !(ir_wr_o || pc_wr_o || reg_wr_o || mem_wr_o || pc_wr_cond_o));

  p_fetch_sel_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ir_wr_o |-> (pc_wr_o && !pc_src_o && alu_b_sel_o == SRCB_FOUR && alu_op_o == ALU_ADD));

  p_regwr_ret_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_o |=> (mem_rd_o && !addr_sel_o));

  p_memwr_ret_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |=> (mem_rd_o && !addr_sel_o));

  p_branch_sel_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_wr_cond_o |-> (pc_src_o && alu_op_o == ALU_SUB && alu_b_sel_o == SRCB_REG));
endmodule

bind mc_ctrl mc_ctrl_chk i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .imem_wait_i(imem_wait_i),
  .dmem_wait_i(dmem_wait_i), .ir_wr_o(ir_wr_o), .pc_wr_o(pc_wr_o),
  .pc_wr_cond_o(pc_wr_cond_o), .pc_src_o(pc_src_o), .addr_sel_o(addr_sel_o),
  .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o), .reg_wr_o(reg_wr_o),
  .alu_b_sel_o(alu_b_sel_o), .alu_op_o(alu_op_o), .state_q(state_q)
);

// File: tb/test_mc_ctrl.sv
module test_mc_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;
  // model step codes
  localparam int M_F = 0, M_D = 1, M_ER = 2, M_WR = 3, M_EO = 4, M_WO = 5,
                 M_EA = 6, M_MR = 7, M_WL = 8, M_MW = 9, M_EB = 10;

  logic clk = 0, rst_ni = 0;
  logic [5:0] opcode = 6'h00;
  logic zero = 0, iwait = 0, dwait = 0;
  logic ir_wr, pc_wr, pc_wr_cond, pc_en, pc_src, addr_sel, mem_rd, mem_wr;
  logic reg_wr, reg_dst, wb_sel, alu_a_sel, ext_sign;
  logic [1:0] alu_b_sel, alu_op;

  int total = 0, bad = 0, cycles = 0, mst = M_F;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mc_ctrl i_mc_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .opcode_i(opcode), .zero_i(zero),
    .imem_wait_i(iwait), .dmem_wait_i(dwait), .ir_wr_o(ir_wr), .pc_wr_o(pc_wr),
    .pc_wr_cond_o(pc_wr_cond), .pc_en_o(pc_en), .pc_src_o(pc_src),
    .addr_sel_o(addr_sel), .mem_rd_o(mem_rd), .mem_wr_o(mem_wr),
    .reg_wr_o(reg_wr), .reg_dst_o(reg_dst), .wb_sel_o(wb_sel),
    .alu_a_sel_o(alu_a_sel), .alu_b_sel_o(alu_b_sel), .alu_op_o(alu_op),
    .ext_sign_o(ext_sign)
  );

  function automatic bit known(input logic [5:0] op);
    return op == 6'h00 || op == 6'h0D || op == 6'h23 || op == 6'h2B || op == 6'h04;
  endfunction

  // bit order: ir pc cond src addr rd wr regwr dst wb a b[2] op[2] ext
  function automatic logic [15:0] expect_vec(input int s, input logic iw, input logic dw);
    logic [15:0] v = 16'h0001;
    case (s)
      M_F:  begin v[10] = 1; v[15] = !iw; v[14] = !iw; end
      M_D:  v[4:3] = 2'b10;
      M_ER: begin v[5] = 1; v[4:3] = 2'b01; v[2:1] = 2'b10; end
      M_WR: begin v[8] = 1; v[7] = 1; end
      M_EO: begin v[5] = 1; v[4:3] = 2'b11; v[2:1] = 2'b11; v[0] = 0; end
      M_WO: v[8] = 1;
      M_EA: begin v[5] = 1; v[4:3] = 2'b11; end
      M_MR: begin v[11] = 1; v[10] = 1; end
      M_WL: begin v[8] = 1; v[6] = 1; end
      M_MW: begin v[11] = 1; v[9] = !dw; end
      M_EB: begin v[5] = 1; v[4:3] = 2'b01; v[2:1] = 2'b01; v[13] = 1; v[12] = 1; end
      default: ;
    endcase
    return v;
  endfunction

  function automatic string tag(input int s, input logic [5:0] op);
    case (s)
      M_F:  return iwait ? "R9" : "R2";
      M_D:  return known(op) ? "R3" : "R11";
      M_ER, M_WR: return "R4";
      M_EO, M_WO: return "R5";
      M_EA: return op == 6'h2B ? "R7" : "R6";
      M_MR: return dwait ? "R10" : "R6";
      M_WL: return "R6";
      M_MW: return dwait ? "R10" : "R7";
      default: return "R8";
    endcase
  endfunction

  function automatic int next_st(input int s, input logic [5:0] op, input logic iw, input logic dw);
    case (s)
      M_F: return iw ? M_F : M_D;
      M_D: case (op)
             6'h00: return M_ER;
             6'h0D: return M_EO;
             6'h23, 6'h2B: return M_EA;
             6'h04: return M_EB;
             default: return M_F;
           endcase
      M_ER: return M_WR;
      M_EO: return M_WO;
      M_EA: return op == 6'h23 ? M_MR : (op == 6'h2B ? M_MW : M_F);
      M_MR: return dw ? M_MR : M_WL;
      M_MW: return dw ? M_MW : M_F;
      default: return M_F;
    endcase
  endfunction

  function automatic logic [15:0] actual_vec();
    return {ir_wr, pc_wr, pc_wr_cond, pc_src, addr_sel, mem_rd, mem_wr, reg_wr,
            reg_dst, wb_sel, alu_a_sel, alu_b_sel, alu_op, ext_sign};
  endfunction

  task automatic check_now();
    logic [15:0] e = expect_vec(mst, iwait, dwait);
    logic [15:0] a = actual_vec();
    logic pe = e[14] | (e[13] & zero);
    total++;
    if (a !== e) begin
      bad++;
      $display("FAIL %s step=%0d actual=%h expected=%h", tag(mst, opcode), mst, a, e);
    end
    total++; // R12 resolved PC enable
    if (pc_en !== pe) begin
      bad++;
      $display("FAIL R12 actual=%b expected=%b", pc_en, pe);
    end
  endtask

  task automatic step(input logic iw, input logic dw, input logic z);
    @(negedge clk);
    iwait = iw; dwait = dw; zero = z;
    #1;
    check_now();
    mst = next_st(mst, opcode, iw, dw);
  endtask

  task automatic run_instr(input logic [5:0] op, input int iws, input int dws, input logic z);
    for (int k = 0; k < iws; k++) step(1, 0, z);
    step(0, 0, z);
    opcode = op;
    while (mst != M_F) begin
      if ((mst == M_MR || mst == M_MW) && dws > 0) begin
        step(0, 1, z);
        dws--;
      end else step(0, 0, z);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      bad++;
      total++;
      $display("FAIL watchdog expired actual=%0d expected<%0d", cycles, WATCHDOG);
      finish_run();
    end
  end

  initial begin
    logic [5:0] ops [6] = '{6'h00, 6'h0D, 6'h23, 6'h2B, 6'h04, 6'h3F};
    // R1: outputs during reset are those of fetch
    iwait = 1;
    #3;
    mst = M_F;
    check_now();
    repeat (2) @(negedge clk);
    rst_ni = 1;
    // R1: first cycle out of reset is fetch
    step(0, 0, 0);
    opcode = 6'h00;
    while (mst != M_F) step(0, 0, 0);
    run_instr(6'h00, 0, 0, 0);  // R4
    run_instr(6'h0D, 2, 0, 0);  // R5, R9
    run_instr(6'h23, 1, 3, 0);  // R6, R10
    run_instr(6'h2B, 0, 2, 0);  // R7, R10
    run_instr(6'h04, 0, 0, 1);  // R8, R12 taken
    run_instr(6'h04, 0, 0, 0);  // R8, R12 not taken
    run_instr(6'h3F, 0, 0, 0);  // R11
    run_instr(6'h10, 1, 0, 1);  // R11
    for (int n = 0; n < 600; n++)
      run_instr(ops[$urandom_range(5)], $urandom_range(3), $urandom_range(3), 1'($urandom_range(1)));
    finish_run();
  end
endmodule